// File: doc/BRIEF.md
# Dual-Port Video Memory Row-Transfer Controller

This block is a small dual-port video memory. A random-access array of rows sits beside a serial access register that holds one full row. A random port, driven by an active-low row strobe, reads and writes single nibbles. A serial port with its own shift clock and a bidirectional nibble bus streams the register in or out, one location per shift-clock rising edge.

When the row strobe falls, the block samples its control inputs and decides what the cycle is. If the transfer/output-enable input is already low, the cycle is a row transfer. The block then copies a whole row into the serial register, copies the register back into a row, reloads only half of the register, or just turns the serial bus around. If the transfer/output-enable input is high, the cycle is an ordinary single-nibble access. A split reload lets a display engine keep streaming one half of the register while the other half is refilled, so the output has no gap.

All strobes and the shift clock are sampled by the system clock `clk`. Their edges are detected synchronously. Every action takes effect on the `clk` edge at which the falling row strobe, or the rising shift clock, is first seen.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: A row-strobe falling edge with `xfer_oe_n` high is a random cycle. With `wr_n` low it writes `rnd_wdata` to location (`row_addr`, `col_addr`). With `wr_n` high it loads that location into `rnd_rdata`. It leaves the serial register, pointer and direction unchanged.
- R2: A transfer (`xfer_oe_n` low at the fall) with `wr_n` high and `spec_fn` low copies the addressed row into the serial register, sets the pointer to 0 and sets `ser_dir` to 0 (output).
- R3: A transfer with `wr_n` high and `spec_fn` high reloads, from the addressed row, only the half of the serial register that does not hold the pointer. The low half is locations 0 to COLS/2-1. The half that holds the pointer, the pointer itself and the current serial output are all unchanged, and `ser_dir` becomes 0.
- R4: A transfer with `wr_n` low, `spec_fn` low and `ser_en_n` high moves no data in either direction and sets `ser_dir` to 1 (input).
- R5: A transfer with `wr_n` low, `spec_fn` low and `ser_en_n` low copies the serial register into the addressed row.
- R6: A transfer with `wr_n` low and `spec_fn` high copies the serial register into the addressed row, whatever the level of `ser_en_n`.
- R7: In output mode (`ser_dir` = 0), with `ser_en_n` low, `ser_dq` shows the register location at the pointer. Each rising edge of `sclk` advances the pointer by one.
- R8: In input mode (`ser_dir` = 1), with `ser_en_n` low, each rising edge of `sclk` stores `ser_dq` at the pointer location and then advances the pointer.
- R9: The pointer wraps from COLS-1 to 0. `act_half` equals 1 exactly when the pointer lies in the high half. Output continues across the half boundary and across the wrap without a skipped location.
- R10: After reset the pointer is 0, `ser_dir` is 0, `act_half` is 0, `rnd_rdata` is 0, and every array and register location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb_n | input | 1 | Active-low row strobe; its falling edge starts a cycle |
| xfer_oe_n | input | 1 | Low at the strobe fall selects a transfer cycle |
| wr_n | input | 1 | Active-low write select, sampled at the strobe fall |
| ser_en_n | input | 1 | Active-low serial enable; also picks the transfer type |
| spec_fn | input | 1 | Special-function select, sampled at the strobe fall |
| row_addr | input | $clog2(ROWS) | Row address |
| col_addr | input | $clog2(COLS) | Column address for random cycles |
| rnd_wdata | input | DW | Random write nibble |
| rnd_rdata | output | DW | Random read nibble, registered |
| sclk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dq | inout | DW | Serial data, driven by the block in output mode |
| ser_dir | output | 1 | Serial direction: 0 output, 1 input |
| act_half | output | 1 | Half of the register holding the pointer (1 = high) |
| ser_ptr | output | $clog2(COLS) | Serial pointer |

## Verification
The assertions check the following on every cycle:
- at most one cycle type is decoded per strobe fall;
- the pointer returns home after a full load;
- the pointer steps by exactly one on each shift edge;
- a split reload holds both the pointer and the current serial output steady;
- the direction flag follows a turnaround or a read transfer;
- a stored row equals what was presented to it.

Some behaviour can only be shown by the bench's scenarios, which replay the data through the ports:
- which locations a split reload actually replaced;
- that a pseudo turnaround left the register contents untouched;
- that the alternate write ignores the serial enable;
- that serial input lands at the right positions.

// File: rtl/vram_xfer_pkg.sv
// Shared types for the video memory row-transfer controller.
// Assumes: one decoded cycle kind per row-strobe falling edge.
package vram_xfer_pkg;
    typedef enum logic [2:0] {
        XK_IDLE,    // no strobe fall this cycle
        XK_RND_RD,  // single nibble read
        XK_RND_WR,  // single nibble write
        XK_READ,    // full row into serial register
        XK_SPLIT,   // reload the inactive half only
        XK_PSEUDO,  // turn serial bus to input, no data
        XK_WRITE,   // serial register into row
        XK_ALTWR    // serial register into row, serial enable ignored
    } xfer_kind_t;
endpackage

// File: rtl/vram_xfer_decode.sv
// Detects the row-strobe falling edge and classifies the cycle from the
// control inputs present at that edge. Assumes controls are stable in the
// clk cycle where the fall is first seen. Output is valid for one cycle.
module vram_xfer_decode
    import vram_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_stb_n,
    input  logic       xfer_oe_n,
    input  logic       wr_n,
    input  logic       ser_en_n,
    input  logic       spec_fn,
    output xfer_kind_t kind
);
    logic stb_q;
    logic stb_fall;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= row_stb_n;
    end

    assign stb_fall = stb_q & ~row_stb_n;

    // Classify the cycle; special function outranks serial enable on writes.
    always_comb begin
        kind = XK_IDLE;
        if (stb_fall) begin
            if (xfer_oe_n)     kind = wr_n ? XK_RND_RD : XK_RND_WR;
            else if (wr_n)     kind = spec_fn ? XK_SPLIT : XK_READ;
            else if (spec_fn)  kind = XK_ALTWR;
            else if (ser_en_n) kind = XK_PSEUDO;
            else               kind = XK_WRITE;
        end
    end

    // R1: a fall is one cycle long, so two decoded cycles never abut
    a_r1_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != XK_IDLE) |=> (kind == XK_IDLE));
endmodule

// File: rtl/vram_row_array.sv
// Random-access array of ROWS rows, each COLS nibbles of DW bits.
// Supports a whole-row write (transfer from the serial register) and a
// single-word write; both reads are combinational. Row write wins.
module vram_row_array #(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    parameter int DW   = 4,
    parameter int RAW  = $clog2(ROWS),
    parameter int CAW  = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RAW-1:0]           row,
    input  logic [CAW-1:0]           col,
    input  logic                     word_we,
    input  logic [DW-1:0]            word_d,
    output logic [DW-1:0]            word_q,
    input  logic                     row_we,
    input  logic [COLS-1:0][DW-1:0]  row_d,
    output logic [COLS-1:0][DW-1:0]  row_q
);
    logic [COLS-1:0][DW-1:0] mem [ROWS];

    // Clear on reset, then apply a row or word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (row_we) begin
            mem[row] <= row_d;
        end else if (word_we) begin
            mem[row][col] <= word_d;
        end
    end

    assign row_q  = mem[row];
    assign word_q = mem[row][col];

    // R5: a row write stores exactly the presented register image
    a_r5_row_stored: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |=> (mem[$past(row)] == $past(row_d)));
endmodule

// File: rtl/vram_sam.sv
// Serial access register of COLS words with a wrapping pointer.
// A full load homes the pointer; a half load refills only the half that
// does not hold the pointer. Assumes COLS is a power of two.
module vram_sam #(
    parameter int COLS = 16,
    parameter int DW   = 4,
    parameter int CAW  = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_full,
    input  logic                     load_half,
    input  logic [COLS-1:0][DW-1:0]  row_d,
    input  logic                     sclk,
    input  logic                     ser_en_n,
    input  logic                     in_mode,
    input  logic [DW-1:0]            ser_in,
    output logic [DW-1:0]            ser_out,
    output logic [CAW-1:0]           ptr,
    output logic                     half,
    output logic [COLS-1:0][DW-1:0]  sam_q
);
    localparam int             HALF = COLS / 2;
    localparam logic [CAW-1:0] STEP = 1;

    logic [COLS-1:0][DW-1:0] sam;
    logic sclk_q;
    logic shift;
    logic reload_hi;

    // Previous shift-clock level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign shift     = sclk & ~sclk_q;
    assign reload_hi = ~ptr[CAW-1];

    // Register contents: full load, half load, or serial capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sam <= '0;
        end else if (load_full) begin
            sam <= row_d;
        end else if (load_half) begin
            for (int c = 0; c < COLS; c++)
                if ((c >= HALF) == reload_hi) sam[c] <= row_d[c];
        end else if (shift && in_mode && !ser_en_n) begin
            sam[ptr] <= ser_in;
        end
    end

    // Pointer: home on full load, step on each shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (load_full) ptr <= '0;
        else if (shift)     ptr <= ptr + STEP;
    end

    assign ser_out = sam[ptr];
    assign half    = ptr[CAW-1];
    assign sam_q   = sam;

    // R2: a full load homes the pointer
    a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        load_full |=> (ptr == '0));
    // R9: each shift edge steps the pointer by one, wrapping at the end
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load_full) |=> (ptr == $past(ptr) + STEP));
    // R3: a half reload keeps the pointer in place
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_half && !shift) |=> $stable(ptr));
    // R3: a half reload does not disturb the word being shifted out
    a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_half && !shift) |=> $stable(ser_out));
endmodule

// File: rtl/vram_xfer_ctrl.sv
// Top of the video memory: row array, serial register, cycle decoder,
// serial direction flag and random read register. Assumes all strobes are
// synchronous to clk and that a transfer and a shift edge do not coincide.
module vram_xfer_ctrl
    import vram_xfer_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    parameter int DW   = 4,
    parameter int RAW  = $clog2(ROWS),
    parameter int CAW  = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_stb_n,
    input  logic            xfer_oe_n,
    input  logic            wr_n,
    input  logic            ser_en_n,
    input  logic            spec_fn,
    input  logic [RAW-1:0]  row_addr,
    input  logic [CAW-1:0]  col_addr,
    input  logic [DW-1:0]   rnd_wdata,
    output logic [DW-1:0]   rnd_rdata,
    input  logic            sclk,
    inout  wire  [DW-1:0]   ser_dq,
    output logic            ser_dir,
    output logic            act_half,
    output logic [CAW-1:0]  ser_ptr
);
    xfer_kind_t              kind;
    logic [COLS-1:0][DW-1:0] arr_row;
    logic [COLS-1:0][DW-1:0] sam_row;
    logic [DW-1:0]           arr_word;
    logic [DW-1:0]           sam_out;
    logic                    row_we;
    logic                    any_read;
    logic                    drive;

    vram_xfer_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_stb_n (row_stb_n),
        .xfer_oe_n (xfer_oe_n),
        .wr_n      (wr_n),
        .ser_en_n  (ser_en_n),
        .spec_fn   (spec_fn),
        .kind      (kind)
    );

    assign row_we   = (kind == XK_WRITE) || (kind == XK_ALTWR);
    assign any_read = (kind == XK_READ) || (kind == XK_SPLIT);

    vram_row_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RAW(RAW), .CAW(CAW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .row     (row_addr),
        .col     (col_addr),
        .word_we (kind == XK_RND_WR),
        .word_d  (rnd_wdata),
        .word_q  (arr_word),
        .row_we  (row_we),
        .row_d   (sam_row),
        .row_q   (arr_row)
    );

    vram_sam #(.COLS(COLS), .DW(DW), .CAW(CAW)) u_sam (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_full (kind == XK_READ),
        .load_half (kind == XK_SPLIT),
        .row_d     (arr_row),
        .sclk      (sclk),
        .ser_en_n  (ser_en_n),
        .in_mode   (ser_dir),
        .ser_in    (ser_dq),
        .ser_out   (sam_out),
        .ptr       (ser_ptr),
        .half      (act_half),
        .sam_q     (sam_row)
    );

    // Serial direction: turnaround sets input, any read transfer sets output.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ser_dir <= 1'b0;
        else if (kind == XK_PSEUDO) ser_dir <= 1'b1;
        else if (any_read)          ser_dir <= 1'b0;
    end

    // Random read register, loaded on a random read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rnd_rdata <= '0;
        else if (kind == XK_RND_RD) rnd_rdata <= arr_word;
    end

    assign drive  = !ser_dir && !ser_en_n;
    assign ser_dq = drive ? sam_out : {DW{1'bz}};

    // R4: a pseudo transfer leaves the serial port in input mode
    a_r4_turn_input: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XK_PSEUDO) |=> ser_dir);
    // R2: read and split transfers leave the serial port in output mode
    a_r2_turn_output: assert property (@(posedge clk) disable iff (!rst_n)
        any_read |=> !ser_dir);
    // R1: a random cycle never moves the pointer or the direction
    a_r1_rnd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == XK_RND_RD || kind == XK_RND_WR) && !sclk) |=> ($stable(ser_ptr) && $stable(ser_dir)));
endmodule

// File: tb/tb_vram_xfer_ctrl.sv
module tb_vram_xfer_ctrl;
    localparam int ROWS = 8;
    localparam int COLS = 16;
    localparam int DW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_stb_n = 1'b1, xfer_oe_n = 1'b1, wr_n = 1'b1, ser_en_n = 1'b0, spec_fn = 1'b0;
    logic [2:0] row_addr = '0;
    logic [3:0] col_addr = '0;
    logic [3:0] rnd_wdata = '0;
    logic [3:0] rnd_rdata;
    logic sclk = 1'b0;
    wire  [3:0] ser_dq;
    logic ser_dir, act_half;
    logic [3:0] ser_ptr;
    logic [3:0] drv = '0;
    logic drv_en = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] mdl [ROWS][COLS];
    logic [3:0] sam_m [COLS];
    int ptr_m = 0;
    bit dir_m = 0;
    logic [3:0] rd_m = '0;

    assign ser_dq = drv_en ? drv : 4'bzzzz;

    always #5 clk = ~clk;

    vram_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .xfer_oe_n(xfer_oe_n),
        .wr_n(wr_n), .ser_en_n(ser_en_n), .spec_fn(spec_fn), .row_addr(row_addr),
        .col_addr(col_addr), .rnd_wdata(rnd_wdata), .rnd_rdata(rnd_rdata),
        .sclk(sclk), .ser_dq(ser_dq), .ser_dir(ser_dir), .act_half(act_half),
        .ser_ptr(ser_ptr)
    );

    // row(3) col(4) data(4) for random writes, read back afterwards
    localparam logic [10:0] VEC [12] = '{
        {3'd0, 4'd1, 4'hA}, {3'd0, 4'd9, 4'h3}, {3'd3, 4'd0, 4'h7}, {3'd3, 4'd15, 4'hC},
        {3'd4, 4'd2, 4'h1}, {3'd4, 4'd8, 4'hF}, {3'd0, 4'd4, 4'h6}, {3'd3, 4'd7, 4'h9},
        {3'd4, 4'd11, 4'h2}, {3'd0, 4'd14, 4'hE}, {3'd3, 4'd5, 4'h4}, {3'd4, 4'd13, 4'h8}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One row-strobe cycle; updates the bench model from the requirements.
    task automatic rcyc(input logic xo, input logic we, input logic se, input logic dsf,
                        input int row, input int col, input logic [3:0] d);
        @(negedge clk);
        xfer_oe_n = xo; wr_n = we; ser_en_n = se; spec_fn = dsf;
        row_addr = 3'(row); col_addr = 4'(col); rnd_wdata = d;
        @(negedge clk);
        row_stb_n = 1'b0;
        @(negedge clk);
        row_stb_n = 1'b1; xfer_oe_n = 1'b1; wr_n = 1'b1; ser_en_n = 1'b0; spec_fn = 1'b0;
        if (xo) begin
            if (!we) mdl[row][col] = d;
            else     rd_m = mdl[row][col];
        end else if (we) begin
            if (!dsf) begin
                for (int c = 0; c < COLS; c++) sam_m[c] = mdl[row][c];
                ptr_m = 0;
            end else begin
                for (int c = 0; c < COLS; c++)
                    if ((c >= COLS/2) == (ptr_m < COLS/2)) sam_m[c] = mdl[row][c];
            end
            dir_m = 0;
        end else if (dsf || !se) begin
            for (int c = 0; c < COLS; c++) mdl[row][c] = sam_m[c];
        end else begin
            dir_m = 1;
        end
    endtask

    // One shift-clock pulse, optionally driving serial input data.
    task automatic spulse(input bit drive_in, input logic [3:0] din);
        @(negedge clk);
        sclk = 1'b1;
        if (drive_in) begin drv_en = 1'b1; drv = din; end
        @(negedge clk);
        sclk = 1'b0; drv_en = 1'b0;
        if (dir_m) sam_m[ptr_m] = din;
        ptr_m = (ptr_m + 1) % COLS;
    endtask

    task automatic sout_chk(input string req);
        chk({req, " ser_dq"}, int'(ser_dq), int'(sam_m[ptr_m]));
        chk({req, " ptr"}, int'(ser_ptr), ptr_m);
        chk({req, " half"}, int'(act_half), (ptr_m >= COLS/2) ? 1 : 0);
    endtask

    task automatic row_chk(input string req, input int row);
        for (int c = 0; c < COLS; c++) begin
            rcyc(1'b1, 1'b1, 1'b0, 1'b0, row, c, 4'h0);
            chk(req, int'(rnd_rdata), int'(rd_m));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) mdl[r][c] = '0;
        for (int c = 0; c < COLS; c++) sam_m[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 ptr", int'(ser_ptr), 0);
        chk("R10 dir", int'(ser_dir), 0);
        chk("R10 half", int'(act_half), 0);
        chk("R10 rdata", int'(rnd_rdata), 0);
        rcyc(1'b1, 1'b1, 1'b0, 1'b0, 5, 9, 4'h0);
        chk("R10 array cleared", int'(rnd_rdata), 0);

        // R1: table of random writes, then read back
        foreach (VEC[i]) rcyc(1'b1, 1'b0, 1'b0, 1'b0, int'(VEC[i][10:8]), int'(VEC[i][7:4]), VEC[i][3:0]);
        foreach (VEC[i]) begin
            rcyc(1'b1, 1'b1, 1'b0, 1'b0, int'(VEC[i][10:8]), int'(VEC[i][7:4]), 4'h0);
            chk("R1 random readback", int'(rnd_rdata), int'(VEC[i][3:0]));
        end

        // fill rows 2 and 5 through the random port
        for (int c = 0; c < COLS; c++) rcyc(1'b1, 1'b0, 1'b0, 1'b0, 2, c, 4'(c ^ 5));
        for (int c = 0; c < COLS; c++) rcyc(1'b1, 1'b0, 1'b0, 1'b0, 5, c, 4'(15 - c));

        // R2: normal read homes a moved pointer and loads the whole row
        repeat (5) spulse(1'b0, 4'h0);
        chk("R7 ptr advanced", int'(ser_ptr), 5);
        rcyc(1'b0, 1'b1, 1'b0, 1'b0, 2, 0, 4'h0);
        chk("R2 ptr home", int'(ser_ptr), 0);
        chk("R2 dir out", int'(ser_dir), 0);
        for (int i = 0; i < COLS; i++) begin sout_chk("R2 R7"); spulse(1'b0, 4'h0); end
        chk("R9 wrap", int'(ser_ptr), 0);

        // R1: a would-be read with xfer_oe_n high is only a random read
        repeat (4) spulse(1'b0, 4'h0);
        rcyc(1'b1, 1'b1, 1'b0, 1'b0, 5, 7, 4'h0);
        chk("R1 random read data", int'(rnd_rdata), int'(mdl[5][7]));
        chk("R1 ptr untouched", int'(ser_ptr), 4);
        sout_chk("R1 register untouched");

        // R3: split with pointer in low half reloads the high half only
        rcyc(1'b0, 1'b1, 1'b0, 1'b1, 5, 0, 4'h0);
        chk("R3 ptr kept", int'(ser_ptr), 4);
        chk("R3 dir out", int'(ser_dir), 0);
        for (int i = 0; i < COLS; i++) begin sout_chk("R3 R9 low-active"); spulse(1'b0, 4'h0); end
        repeat (6) spulse(1'b0, 4'h0);
        chk("R9 half high", int'(act_half), 1);
        // R3: split with pointer in high half reloads the low half only
        rcyc(1'b0, 1'b1, 1'b0, 1'b1, 2, 0, 4'h0);
        chk("R3 ptr kept high", int'(ser_ptr), 10);
        for (int i = 0; i < COLS; i++) begin sout_chk("R3 R9 high-active"); spulse(1'b0, 4'h0); end

        // R4: pseudo transfer from a zero row turns the bus and moves nothing
        rcyc(1'b0, 1'b0, 1'b1, 1'b0, 1, 0, 4'h0);
        chk("R4 dir in", int'(ser_dir), 1);
        chk("R4 ptr kept", int'(ser_ptr), ptr_m);
        // R5: normal write stores the untouched register into row 6
        rcyc(1'b0, 1'b0, 1'b0, 1'b0, 6, 0, 4'h0);
        row_chk("R5 R4 row6", 6);

        // R8: serial input fills the register
        for (int i = 0; i < COLS; i++) spulse(1'b1, 4'((i * 3 + 1) & 15));
        // R6: alternate write with serial enable high
        rcyc(1'b0, 1'b0, 1'b1, 1'b1, 7, 0, 4'h0);
        chk("R6 dir kept", int'(ser_dir), 1);
        row_chk("R6 R8 row7", 7);
        // R6: alternate write with serial enable low
        rcyc(1'b0, 1'b0, 1'b0, 1'b1, 3, 0, 4'h0);
        row_chk("R6 row3", 3);

        // R2: read back row 7 through the serial port
        rcyc(1'b0, 1'b1, 1'b0, 1'b0, 7, 0, 4'h0);
        chk("R2 dir back out", int'(ser_dir), 0);
        for (int i = 0; i < COLS; i++) begin sout_chk("R2 R8 replay"); spulse(1'b0, 4'h0); end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule